// File: doc/BRIEF.md
# Double-Size Glyph Pixel Postprocessor

This block sits between the glyph row fetch and the colour stage of an on-screen text overlay. For each character scan line, the caller presents three glyph rows at once: the row above, the current row and the row below. It also gives the display mode for that line. The block latches this window on a single start pulse. It then streams one result per dot clock. Each result carries a foreground flag, a fringe flag and a blank flag that drives the video switch.

In normal size, each glyph column yields one dot. In double size, each column yields two dots. The caller presents every glyph row twice, once for the upper half and once for the lower half, so the character is doubled in both directions. At double size, optional smoothing fills the half-cell sub-dots that sit in the inside corner of a diagonal step. Optional fringing marks a one-pixel outline around the strokes. Glyph storage and colour mapping live elsewhere.

Top module: `ppx_glyph_post`

## Requirements
- R1: After reset, and with no line started, `dot_vld`, `dot_fg`, `dot_fringe` and `dot_blank` are all 0.
- R2: Let `scan_start` be sampled high at clock edge E. Dot k of that line is then on the outputs right after edge E+1+k, with `dot_vld`=1. A line has GW dots in normal size and 2*GW in double size. `dot_vld` returns to 0 after the last dot when no new line starts.
- R3: In normal size, dot k (k = 0..GW-1) shows glyph column k, and column k is bit k of a row (dots go LSB first). Dot k has `dot_fg` equal to bit k of the current row.
- R4: In double size, dot d shows column d/2; d even is the left half and d odd is the right half. `lower_half`=0 selects the upper half line and 1 selects the lower half line. With smoothing off, `dot_fg` equals current-row bit d/2.
- R5: Smoothing sets `dot_fg` on a background sub-dot when three conditions hold:
  - the vertical neighbour toward its half is set (row above for the upper half, row below for the lower half);
  - the horizontal neighbour toward its half is set (column-1 for the left half, column+1 for the right half);
  - the pixel diagonal between those two is clear.
- R6: Smoothing acts only when `dbl_size`=1 and `smooth_en`=1. In normal size, `smooth_en` has no effect on any output.
- R7: With `fringe_en`=1, `dot_fringe`=1 exactly on dots where `dot_fg`=0 and at least one of the eight neighbouring glyph pixels is set. Neighbours are taken in the three-row window at source-pixel resolution. `dot_fg` and `dot_fringe` are never both 1.
- R8: With `fringe_en`=0, `dot_fringe` stays 0 for every dot.
- R9: `row_is_top`=1 makes the row above count as all zero. `row_is_bottom`=1 makes the row below count as all zero. This applies to both fringing and smoothing. Columns outside 0..GW-1 always count as zero.
- R10: `dot_blank` equals `dot_fg` OR `dot_fringe` on valid dots. All three flags are 0 whenever `dot_vld`=0.
- R11: Rows, edge flags and mode inputs are sampled only when `scan_start` is high. Changing them during a line does not alter that line's dots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_start | input | 1 | Start pulse; samples window and mode |
| row_prev | input | GW | Glyph row above the current one |
| row_cur | input | GW | Glyph row being displayed |
| row_next | input | GW | Glyph row below the current one |
| row_is_top | input | 1 | Current row is the glyph's first row |
| row_is_bottom | input | 1 | Current row is the glyph's last row |
| dbl_size | input | 1 | Double-size mode |
| smooth_en | input | 1 | Enable diagonal smoothing at double size |
| fringe_en | input | 1 | Enable one-pixel outline |
| lower_half | input | 1 | Lower half line of a doubled row |
| dot_vld | output | 1 | Dot outputs valid |
| dot_fg | output | 1 | Dot is foreground |
| dot_fringe | output | 1 | Dot is outline |
| dot_blank | output | 1 | Overlay switch for this dot |

## Verification
The assertions assume the following about the inputs:
- `scan_start` is a single-cycle pulse.
- A new line starts only after the previous one has drained, so the latency and idle-output properties compare a clean start against a clean end.
- The mode bits mean something only at the start pulse.

The stimulus keeps within these limits. It raises `scan_start` for exactly one cycle and waits one idle dot after every line before the next. It also scrambles all window and mode inputs during a line only in the dedicated R11 run.

// File: rtl/ppx_pkg.sv
package ppx_pkg;

  typedef struct packed {
    logic dbl;
    logic smooth;
    logic fringe;
    logic lower;
  } ppx_mode_t;

  function automatic int ppx_line_dots(input int gw, input logic dbl);
    return dbl ? 2 * gw : gw;
  endfunction

endpackage

// File: rtl/ppx_row_window.sv
module ppx_row_window
  import ppx_pkg::*;
#(
  parameter int GW = 8,
  localparam int IW = $clog2(2 * GW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scan_start,
  input  logic [GW-1:0] row_prev,
  input  logic [GW-1:0] row_cur,
  input  logic [GW-1:0] row_next,
  input  logic          row_is_top,
  input  logic          row_is_bottom,
  input  ppx_mode_t     mode_in,
  output logic [GW-1:0] w_prev,
  output logic [GW-1:0] w_cur,
  output logic [GW-1:0] w_next,
  output ppx_mode_t     w_mode,
  output logic          w_active,
  output logic [IW-1:0] w_idx,
  output logic          w_last
);

  localparam logic [IW-1:0] LAST_NORM = IW'(ppx_line_dots(GW, 1'b0) - 1);
  localparam logic [IW-1:0] LAST_DBL  = IW'(ppx_line_dots(GW, 1'b1) - 1);

  assign w_last = w_active && (w_idx == (w_mode.dbl ? LAST_DBL : LAST_NORM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_prev   <= '0;
      w_cur    <= '0;
      w_next   <= '0;
      w_mode   <= '0;
      w_active <= 1'b0;
      w_idx    <= '0;
    end else if (scan_start) begin
      w_prev   <= row_is_top    ? '0 : row_prev;
      w_cur    <= row_cur;
      w_next   <= row_is_bottom ? '0 : row_next;
      w_mode   <= mode_in;
      w_active <= 1'b1;
      w_idx    <= '0;
    end else if (w_active) begin
      if (w_last) begin
        w_active <= 1'b0;
        w_idx    <= '0;
      end else begin
        w_idx <= w_idx + 1'b1;
      end
    end
  end

  AST_IDX_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    w_active |-> (w_idx <= (w_mode.dbl ? LAST_DBL : LAST_NORM))); // R2

  AST_IDLE_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !w_active |-> (w_idx == '0)); // R2

endmodule

// File: rtl/ppx_dot_eval.sv
module ppx_dot_eval
  import ppx_pkg::*;
#(
  parameter int GW = 8,
  localparam int IW = $clog2(2 * GW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [GW-1:0] w_prev,
  input  logic [GW-1:0] w_cur,
  input  logic [GW-1:0] w_next,
  input  ppx_mode_t     w_mode,
  input  logic [IW-1:0] w_idx,
  output logic          fg_d,
  output logic          fringe_d,
  output logic          smooth_hit
);

  function automatic logic bit_at(input logic [GW-1:0] r, input int c);
    logic b;
    b = 1'b0;
    for (int i = 0; i < GW; i++)
      if (i == c) b = r[i];
    return b;
  endfunction

  function automatic logic any_neighbour(input logic [GW-1:0] p,
                                         input logic [GW-1:0] c,
                                         input logic [GW-1:0] n,
                                         input int j);
    logic hit;
    hit = bit_at(c, j - 1) | bit_at(c, j + 1);
    for (int dc = -1; dc <= 1; dc++)
      hit = hit | bit_at(p, j + dc) | bit_at(n, j + dc);
    return hit;
  endfunction

  function automatic logic corner_fill(input logic [GW-1:0] p,
                                       input logic [GW-1:0] c,
                                       input logic [GW-1:0] n,
                                       input int j,
                                       input logic right,
                                       input logic lower);
    logic [GW-1:0] vrow;
    int            hc;
    vrow = lower ? n : p;
    hc   = right ? j + 1 : j - 1;
    return !bit_at(c, j) && bit_at(vrow, j) && bit_at(c, hc) && !bit_at(vrow, hc);
  endfunction

  int   col;
  logic half_right;
  logic src_on;

  always_comb begin
    col        = w_mode.dbl ? int'(w_idx >> 1) : int'(w_idx);
    half_right = w_mode.dbl & w_idx[0];
    src_on     = bit_at(w_cur, col);
    smooth_hit = w_mode.dbl && w_mode.smooth &&
                 corner_fill(w_prev, w_cur, w_next, col, half_right, w_mode.lower);
    fg_d       = src_on | smooth_hit;
    fringe_d   = w_mode.fringe && !fg_d && any_neighbour(w_prev, w_cur, w_next, col);
  end

  AST_FRINGE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !w_mode.fringe |-> !fringe_d); // R8

  AST_SMOOTH_NEEDS_DBL: assert property (@(posedge clk) disable iff (!rst_n)
    smooth_hit |-> (w_mode.dbl && w_mode.smooth)); // R6

endmodule

// File: rtl/ppx_out_stage.sv
module ppx_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic fg_d,
  input  logic fringe_d,
  output logic dot_vld,
  output logic dot_fg,
  output logic dot_fringe,
  output logic dot_blank
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot_vld    <= 1'b0;
      dot_fg     <= 1'b0;
      dot_fringe <= 1'b0;
      dot_blank  <= 1'b0;
    end else begin
      dot_vld    <= active;
      dot_fg     <= active & fg_d;
      dot_fringe <= active & fringe_d;
      dot_blank  <= active & (fg_d | fringe_d);
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dot_vld |-> !(dot_fg || dot_fringe || dot_blank)); // R10

  AST_FG_FRINGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    dot_fg |-> !dot_fringe); // R7

endmodule

// File: rtl/ppx_glyph_post.sv
module ppx_glyph_post
  import ppx_pkg::*;
#(
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scan_start,
  input  logic [GW-1:0] row_prev,
  input  logic [GW-1:0] row_cur,
  input  logic [GW-1:0] row_next,
  input  logic          row_is_top,
  input  logic          row_is_bottom,
  input  logic          dbl_size,
  input  logic          smooth_en,
  input  logic          fringe_en,
  input  logic          lower_half,
  output logic          dot_vld,
  output logic          dot_fg,
  output logic          dot_fringe,
  output logic          dot_blank
);

  localparam int IW = $clog2(2 * GW);

  ppx_mode_t     mode_in;
  ppx_mode_t     w_mode;
  logic [GW-1:0] w_prev, w_cur, w_next;
  logic          w_active, w_last;
  logic [IW-1:0] w_idx;
  logic          fg_d, fringe_d, smooth_hit;

  assign mode_in = '{dbl: dbl_size, smooth: smooth_en, fringe: fringe_en, lower: lower_half};

  ppx_row_window #(.GW(GW)) u_win (
    .clk(clk), .rst_n(rst_n), .scan_start(scan_start),
    .row_prev(row_prev), .row_cur(row_cur), .row_next(row_next),
    .row_is_top(row_is_top), .row_is_bottom(row_is_bottom), .mode_in(mode_in),
    .w_prev(w_prev), .w_cur(w_cur), .w_next(w_next), .w_mode(w_mode),
    .w_active(w_active), .w_idx(w_idx), .w_last(w_last)
  );

  ppx_dot_eval #(.GW(GW)) u_eval (
    .clk(clk), .rst_n(rst_n),
    .w_prev(w_prev), .w_cur(w_cur), .w_next(w_next), .w_mode(w_mode), .w_idx(w_idx),
    .fg_d(fg_d), .fringe_d(fringe_d), .smooth_hit(smooth_hit)
  );

  ppx_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .active(w_active), .fg_d(fg_d), .fringe_d(fringe_d),
    .dot_vld(dot_vld), .dot_fg(dot_fg), .dot_fringe(dot_fringe), .dot_blank(dot_blank)
  );

  AST_TWO_DOT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    scan_start |-> ##2 dot_vld); // R2

  AST_LINE_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (w_last && !scan_start) |=> ##1 !dot_vld); // R2

endmodule

// File: tb/tb_ppx_glyph_post.sv
module tb_ppx_glyph_post;

  localparam int GW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          scan_start = 1'b0;
  logic [GW-1:0] row_prev = '0, row_cur = '0, row_next = '0;
  logic          row_is_top = 1'b0, row_is_bottom = 1'b0;
  logic          dbl_size = 1'b0, smooth_en = 1'b0, fringe_en = 1'b0, lower_half = 1'b0;
  logic          dot_vld, dot_fg, dot_fringe, dot_blank;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  ppx_glyph_post #(.GW(GW)) dut (
    .clk(clk), .rst_n(rst_n), .scan_start(scan_start),
    .row_prev(row_prev), .row_cur(row_cur), .row_next(row_next),
    .row_is_top(row_is_top), .row_is_bottom(row_is_bottom),
    .dbl_size(dbl_size), .smooth_en(smooth_en), .fringe_en(fringe_en),
    .lower_half(lower_half),
    .dot_vld(dot_vld), .dot_fg(dot_fg), .dot_fringe(dot_fringe), .dot_blank(dot_blank)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 190000) begin
      n_checks = n_checks + 1;
      n_fail   = n_fail + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected fewer", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_checks = n_checks + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual vld/fg/fr/blank=%b expected %b", tag, act, exp);
    end
  endtask

  // Reference: padded 3-row grid, neighbour count, corner rule.
  function automatic logic [1:0] ref_dot(input logic [GW-1:0] p, input logic [GW-1:0] c,
                                         input logic [GW-1:0] n, input logic top,
                                         input logic bot, input logic dbl, input logic sm,
                                         input logic fr, input logic low, input int d);
    logic g [0:2][0:GW+1];
    int   col, hx, vr, hc, cnt;
    logic fg, fri;
    for (int r = 0; r < 3; r++)
      for (int k = 0; k < GW + 2; k++) g[r][k] = 1'b0;
    for (int k = 0; k < GW; k++) begin
      g[0][k+1] = top ? 1'b0 : p[k];
      g[1][k+1] = c[k];
      g[2][k+1] = bot ? 1'b0 : n[k];
    end
    col = dbl ? d / 2 : d;
    hx  = d % 2;
    fg  = g[1][col+1];
    if (dbl && sm && !fg) begin
      vr = low ? 2 : 0;
      hc = (hx == 1) ? col + 2 : col;
      if (g[vr][col+1] && g[1][hc] && !g[vr][hc]) fg = 1'b1;
    end
    cnt = 0;
    for (int r = 0; r < 3; r++)
      for (int k = col; k <= col + 2; k++)
        if (!(r == 1 && k == col + 1) && g[r][k]) cnt++;
    fri = fr && !fg && (cnt > 0);
    return {fg, fri};
  endfunction

  task automatic run_line(input string tag, input logic [GW-1:0] p, input logic [GW-1:0] c,
                          input logic [GW-1:0] n, input logic top, input logic bot,
                          input logic dbl, input logic sm, input logic fr, input logic low,
                          input bit scramble);
    int dots;
    logic [1:0] e;
    dots = dbl ? 2 * GW : GW;
    @(negedge clk);
    row_prev = p; row_cur = c; row_next = n; row_is_top = top; row_is_bottom = bot;
    dbl_size = dbl; smooth_en = sm; fringe_en = fr; lower_half = low;
    scan_start = 1'b1;
    @(negedge clk);
    scan_start = 1'b0;
    if (scramble) begin
      row_prev = ~p; row_cur = ~c; row_next = ~n; row_is_top = ~top; row_is_bottom = ~bot;
      dbl_size = ~dbl; smooth_en = ~sm; fringe_en = ~fr; lower_half = ~low;
    end
    for (int k = 0; k < dots; k++) begin
      @(negedge clk);
      e = ref_dot(p, c, n, top, bot, dbl, sm, fr, low, k);
      check(tag, {dot_vld, dot_fg, dot_fringe, dot_blank}, {1'b1, e[1], e[0], e[1] | e[0]});
      check("R10", {1'b0, 1'b0, 1'b0, dot_blank}, {1'b0, 1'b0, 1'b0, dot_fg | dot_fringe});
    end
    @(negedge clk);
    check("R2 drain", {dot_vld, dot_fg, dot_fringe, dot_blank}, 4'b0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {dot_vld, dot_fg, dot_fringe, dot_blank}, 4'b0000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", {dot_vld, dot_fg, dot_fringe, dot_blank}, 4'b0000);

    // R3, R7: full normal-size sweep with fringe on
    for (int v = 0; v < 4096; v++) begin
      logic [11:0] b = v[11:0];
      run_line("R3,R7", b[3:0], b[7:4], b[11:8], 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    end
    // R5: full double-size sweep with smoothing, varied half and fringe
    for (int v = 0; v < 4096; v++) begin
      logic [11:0] b = v[11:0];
      run_line("R5", b[3:0], b[7:4], b[11:8], 1'b0, 1'b0, 1'b1, 1'b1, b[1], b[0] ^ b[6], 1'b0);
    end
    for (int v = 0; v < 4096; v += 16) begin
      logic [11:0] b = v[11:0] ^ 12'h5A3;
      // R6: smoothing request in normal size
      run_line("R6", b[3:0], b[7:4], b[11:8], 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, b[2], 1'b0);
      // R4: double size, no smoothing
      run_line("R4", b[3:0], b[7:4], b[11:8], 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, b[5], 1'b0);
      // R8: fringe off
      run_line("R8", b[3:0], b[7:4], b[11:8], 1'b0, 1'b0, b[0], 1'b1, 1'b0, b[9], 1'b0);
      // R9: edge rows masked
      run_line("R9", b[3:0], b[7:4], b[11:8], 1'b1, b[4], 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      run_line("R9", b[3:0], b[7:4], b[11:8], b[8], 1'b1, 1'b1, 1'b1, 1'b1, b[3], 1'b0);
    end
    // R11: inputs scrambled mid-line
    run_line("R11", 4'b0010, 4'b0101, 4'b1000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    run_line("R11", 4'b1100, 4'b0011, 4'b0110, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    run_line("R11", 4'b0001, 4'b0100, 4'b0010, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule